// File: doc/BRIEF.md
# Encoder Compare and Interrupt Aggregator

This block sits beside a quadrature-decoder position counter and revolution (index) counter. It holds three position reference values and one revolution reference value. It watches the live counts for the moment each reference is reached and raises a flag at that moment. Six other event sources come in as single-cycle pulses from the decoder: index seen, velocity timer overflow, velocity below its limit, direction change, phase error and encoder clock. All these events are gathered into one sticky 13-bit status word.

Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read path. Software can write the reference values. It can force or clear status bits with write-one registers. It can load the enable mask directly, or change single enable bits through set and clear registers. A single registered interrupt line reports whether any enabled status bit is pending. Three combined flags mark that a position match and a revolution match are pending at the same time.

Top module: `enc_cmp_irq`

## Requirements
- R1: After reset the status word, the enable mask, all four reference registers and `irq_o` read as zero.
- R2: A one-cycle pulse on `src_evt[k]` (k = 0..5) sets status bit k. The bits are: 0 index seen, 1 timer overflow, 2 velocity below limit, 3 direction change, 4 phase error, 5 encoder clock.
- R3: Position channel k (k = 0..2) sets status bit 6+k at the clock edge where `pos_cnt` first equals reference k. The bit is not set again while the equality holds, and an equality already present when reset ends does not set it.
- R4: Status bit 9 sets at the clock edge where `idx_cnt` first equals the revolution reference. The same first-cycle rule as in R3 applies.
- R5: Combined bit 10+k is set in the same edge that leaves both bit 6+k and bit 9 set. The cause may be hardware or software. Clearing the combined bit alone while both sources stay set has no effect.
- R6: Status bits are sticky. Writing to address 6 clears every status bit written as one; all other bits are kept.
- R7: Writing to address 5 sets every status bit written as one. Data bits 13 and above are ignored.
- R8: When a hardware event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: Address 7 loads the enable mask, address 8 sets mask bits written as one, and address 9 clears them. Only bits 12..0 are stored.
- R10: `irq_o` is a flop that is high exactly when some status bit and its enable bit are both set. It changes in the same edge as the status word.
- R11: The register map is: 0..2 position references, 3 revolution reference, 4 status (read only), 7 enable. Reference registers keep only their low POS_W or IDX_W bits. Unmapped addresses read zero, and a write to address 4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_cnt | input | POS_W | Live position count |
| idx_cnt | input | IDX_W | Live revolution count |
| src_evt | input | 6 | Event pulses for status bits 0..5 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with POS_W=12 and IDX_W=8, which are narrower than the 32-bit data path. Writing wide values to the references therefore shows truncation on readback. It also lets the revolution reference sit at its top value (0xFF), reached by a short count. A scoreboard checks the status word after event pulses, compare crossings, software set and clear writes and same-cycle collisions. It also checks that the combined flags rearm when their sources remain pending.

// File: rtl/enc_irq_pkg.sv
package enc_irq_pkg;
   // event layout: pulse sources, then position matches, index match, combined
   localparam int unsigned N_SRC   = 6;
   localparam int unsigned N_POS   = 3;
   localparam int unsigned B_POS0  = N_SRC;
   localparam int unsigned B_IDX   = B_POS0 + N_POS;
   localparam int unsigned B_COMB0 = B_IDX + 1;
   localparam int unsigned STAT_W  = B_COMB0 + N_POS;
   localparam int unsigned HW_W    = B_COMB0;

   // register addresses
   localparam int unsigned A_POS0  = 0;
   localparam int unsigned A_IDX   = A_POS0 + N_POS;
   localparam int unsigned A_STAT  = A_IDX + 1;
   localparam int unsigned A_SSET  = A_STAT + 1;
   localparam int unsigned A_SCLR  = A_SSET + 1;
   localparam int unsigned A_EN    = A_SCLR + 1;
   localparam int unsigned A_ESET  = A_EN + 1;
   localparam int unsigned A_ECLR  = A_ESET + 1;
   localparam int unsigned A_LAST  = A_ECLR;
endpackage

// File: rtl/enc_cmp_match.sv
module enc_cmp_match #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ref_val,
   input  logic [W-1:0] live_val,
   output logic         hit_o
);
   logic eq_now;
   logic eq_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("enc_cmp_match: W must be at least 1");
      end
   endgenerate

   assign eq_now = (ref_val == live_val);

   // starts as "already equal" so a match present at reset end is not new
   always_ff @(posedge clk) begin
      if (!rst_n) eq_q <= 1'b1;
      else        eq_q <= eq_now;
   end

   assign hit_o = eq_now & ~eq_q;

   // R3/R4: a crossing is reported for one cycle only
   assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);
endmodule

// File: rtl/enc_irq_status.sv
module enc_irq_status
   import enc_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HW_W-1:0]   hw_evt,
   input  logic [STAT_W-1:0] sw_set,
   input  logic [STAT_W-1:0] sw_clr,
   input  logic              en_load,
   input  logic [STAT_W-1:0] en_wdata,
   input  logic [STAT_W-1:0] en_set,
   input  logic [STAT_W-1:0] en_clr,
   output logic [STAT_W-1:0] stat_q,
   output logic [STAT_W-1:0] en_q,
   output logic              irq_o
);
   logic [HW_W-1:0]   base_nxt;
   logic [STAT_W-1:0] hw_all;
   logic [STAT_W-1:0] stat_d;
   logic [STAT_W-1:0] en_d;

   always_comb begin
      base_nxt = (stat_q[HW_W-1:0] | sw_set[HW_W-1:0] | hw_evt)
               & ~(sw_clr[HW_W-1:0] & ~hw_evt);
      hw_all = '0;
      hw_all[HW_W-1:0] = hw_evt;
      for (int n = 0; n < N_POS; n++) begin
         hw_all[B_COMB0+n] = base_nxt[B_POS0+n] & base_nxt[B_IDX];
      end
      // hardware wins over a same-cycle software clear
      stat_d = (stat_q | sw_set | hw_all) & ~(sw_clr & ~hw_all);
      if (en_load) en_d = en_wdata;
      else         en_d = (en_q | en_set) & ~en_clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         en_q   <= '0;
         irq_o  <= 1'b0;
      end else begin
         stat_q <= stat_d;
         en_q   <= en_d;
         irq_o  <= |(stat_d & en_d);
      end
   end

   genvar i;
   generate
      for (i = 0; i < STAT_W; i++) begin : g_bit_chk
         assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hw_all[i] |=> stat_q[i]);
      end
      for (i = 0; i < N_POS; i++) begin : g_comb_chk
         assert_comb_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[B_POS0+i] && stat_q[B_IDX]) |-> stat_q[B_COMB0+i]);
      end
   endgenerate

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(stat_q & ~sw_clr)) == $past(stat_q & ~sw_clr)));

   assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (|(stat_q & en_q)));
endmodule

// File: rtl/enc_cmp_irq.sv
module enc_cmp_irq
   import enc_irq_pkg::*;
#(
   parameter int unsigned POS_W  = 16,
   parameter int unsigned IDX_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [POS_W-1:0]  pos_cnt,
   input  logic [IDX_W-1:0]  idx_cnt,
   input  logic [N_SRC-1:0]  src_evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);
   generate
      if (POS_W < 1 || POS_W > DATA_W) begin : g_bad_pos
         $error("enc_cmp_irq: POS_W must be 1..DATA_W");
      end
      if (IDX_W < 1 || IDX_W > DATA_W) begin : g_bad_idx
         $error("enc_cmp_irq: IDX_W must be 1..DATA_W");
      end
      if (DATA_W < STAT_W) begin : g_bad_data
         $error("enc_cmp_irq: DATA_W too narrow for status word");
      end
      if ((1 << ADDR_W) <= A_LAST) begin : g_bad_addr
         $error("enc_cmp_irq: ADDR_W too narrow for register map");
      end
   endgenerate

   logic [POS_W-1:0]  pos_ref [N_POS];
   logic [IDX_W-1:0]  idx_ref;
   logic [N_POS-1:0]  pos_hit;
   logic              idx_hit;
   logic [STAT_W-1:0] stat_q, en_q;
   logic [STAT_W-1:0] sw_set, sw_clr, en_set, en_clr;
   logic              en_load;
   logic              unused_wdata;

   assign unused_wdata = ^wr_data;

   function automatic logic wr_at(input int unsigned a);
      return wr_en && (wr_addr == ADDR_W'(a));
   endfunction

   genvar k;
   generate
      for (k = 0; k < N_POS; k++) begin : g_pos
         always_ff @(posedge clk) begin
            if (!rst_n)                pos_ref[k] <= '0;
            else if (wr_at(A_POS0+k))  pos_ref[k] <= wr_data[POS_W-1:0];
         end

         enc_cmp_match #(.W(POS_W)) u_pos_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_val  (pos_ref[k]),
            .live_val (pos_cnt),
            .hit_o    (pos_hit[k])
         );

         assert_ref_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(A_POS0+k)) |=> $stable(pos_ref[k]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          idx_ref <= '0;
      else if (wr_at(A_IDX)) idx_ref <= wr_data[IDX_W-1:0];
   end

   enc_cmp_match #(.W(IDX_W)) u_idx_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_val  (idx_ref),
      .live_val (idx_cnt),
      .hit_o    (idx_hit)
   );

   assign sw_set  = wr_at(A_SSET) ? wr_data[STAT_W-1:0] : '0;
   assign sw_clr  = wr_at(A_SCLR) ? wr_data[STAT_W-1:0] : '0;
   assign en_set  = wr_at(A_ESET) ? wr_data[STAT_W-1:0] : '0;
   assign en_clr  = wr_at(A_ECLR) ? wr_data[STAT_W-1:0] : '0;
   assign en_load = wr_at(A_EN);

   enc_irq_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_evt   ({idx_hit, pos_hit, src_evt}),
      .sw_set   (sw_set),
      .sw_clr   (sw_clr),
      .en_load  (en_load),
      .en_wdata (wr_data[STAT_W-1:0]),
      .en_set   (en_set),
      .en_clr   (en_clr),
      .stat_q   (stat_q),
      .en_q     (en_q),
      .irq_o    (irq_o)
   );

   always_comb begin
      rd_data = '0;
      for (int n = 0; n < N_POS; n++) begin
         if (rd_addr == ADDR_W'(A_POS0+n)) rd_data[POS_W-1:0] = pos_ref[n];
      end
      if (rd_addr == ADDR_W'(A_IDX))  rd_data[IDX_W-1:0]  = idx_ref;
      if (rd_addr == ADDR_W'(A_STAT)) rd_data[STAT_W-1:0] = stat_q;
      if (rd_addr == ADDR_W'(A_EN))   rd_data[STAT_W-1:0] = en_q;
   end

   assert_stat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(A_STAT) && src_evt == '0 && pos_hit == '0 && !idx_hit)
      |=> (stat_q == $past(stat_q)));
endmodule

// File: tb/enc_cmp_irq_tb.sv
module enc_cmp_irq_tb;
   localparam int POS_W = 12, IDX_W = 8, DATA_W = 32, ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [POS_W-1:0]  pos_cnt;
   logic [IDX_W-1:0]  idx_cnt;
   logic [5:0]        src_evt;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              irq_o;

   always #4 clk = ~clk;   // 125 MHz

   enc_cmp_irq #(.POS_W(POS_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .pos_cnt(pos_cnt), .idx_cnt(idx_cnt), .src_evt(src_evt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   typedef struct {
      int                kind;   // 0 read data, 1 interrupt line
      logic [DATA_W-1:0] exp;
      string             tag;
   } chk_t;

   chk_t  sb_q[$];
   chk_t  cur;
   event  probe_ev;
   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 0;
   logic [DATA_W-1:0] got;

   // monitor: pops expected items and compares them with the outputs
   always begin
      @(probe_ev);
      #2;
      while (sb_q.size() > 0) begin
         cur = sb_q.pop_front();
         got = (cur.kind == 0) ? rd_data : {{(DATA_W-1){1'b0}}, irq_o};
         n_chk++;
         if (got !== cur.exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", cur.tag, got, cur.exp);
         end
      end
   end

   task automatic expect_rd(input int a, input logic [DATA_W-1:0] e, input string tag);
      chk_t it;
      rd_addr = ADDR_W'(a);
      it.kind = 0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      ->probe_ev;
      #3;
   endtask

   task automatic expect_irq(input logic e, input string tag);
      chk_t it;
      it.kind = 1; it.exp = {{(DATA_W-1){1'b0}}, e}; it.tag = tag;
      sb_q.push_back(it);
      ->probe_ev;
      #3;
   endtask

   task automatic wr(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [5:0] e);
      @(negedge clk);
      src_evt = e;
      @(negedge clk);
      src_evt = '0;
   endtask

   task automatic set_pos(input logic [POS_W-1:0] p);
      @(negedge clk);
      pos_cnt = p;
      @(negedge clk);
   endtask

   task automatic set_idx(input logic [IDX_W-1:0] p);
      @(negedge clk);
      idx_cnt = p;
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; pos_cnt = '0; idx_cnt = '0; src_evt = '0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state; R3 match present at reset end raises nothing
      expect_rd(4, 32'h0, "R1 status after reset (R3 no flag at reset)");
      expect_rd(7, 32'h0, "R1 enable after reset");
      expect_irq(1'b0, "R1 irq after reset");
      expect_rd(0, 32'h0, "R1 position ref 0 after reset");
      expect_rd(3, 32'h0, "R1 revolution ref after reset");

      // R2 event pulses
      pulse(6'b000101);
      expect_rd(4, 32'h005, "R2 pulses on bits 0 and 2");
      pulse(6'b111010);
      expect_rd(4, 32'h03F, "R2 all six pulse sources");

      // R6 write-one clear
      wr(6, 32'h03F);
      expect_rd(4, 32'h000, "R6 clear of pulse bits");

      // R7 write-one set
      wr(5, 32'h002);
      expect_rd(4, 32'h002, "R7 software set bit 1");
      expect_irq(1'b0, "R10 irq low with mask zero");

      // R9 enable mask, R10 interrupt
      wr(7, 32'hFFFF_FFFF);
      expect_rd(7, 32'h1FFF, "R9 enable load keeps 13 bits");
      expect_irq(1'b1, "R10 irq high when enabled bit pending");
      wr(9, 32'h2);
      expect_rd(7, 32'h1FFD, "R9 enable clear");
      expect_irq(1'b0, "R10 irq low after enable cleared");
      wr(8, 32'h2);
      expect_rd(7, 32'h1FFF, "R9 enable set");
      expect_irq(1'b1, "R10 irq back high");
      wr(6, 32'h2);
      expect_rd(4, 32'h000, "R6 clear bit 1");
      expect_irq(1'b0, "R10 irq low after status clear");
      wr(7, 32'h0);
      expect_rd(7, 32'h0, "R9 enable load zero");

      // R11 reference registers and truncation
      wr(0, 32'h123);
      wr(1, 32'h456);
      wr(2, 32'hFABC);
      wr(3, 32'h05);
      expect_rd(0, 32'h123, "R11 position ref 0 readback");
      expect_rd(2, 32'hABC, "R11 position ref 2 truncated to POS_W");
      expect_rd(3, 32'h05,  "R11 revolution ref readback");
      expect_rd(4, 32'h000, "R3 leaving equality raises nothing");

      // R3 first-cycle compare
      set_pos(12'h123);
      expect_rd(4, 32'h040, "R3 position 0 match");
      repeat (3) @(negedge clk);
      wr(6, 32'h040);
      repeat (2) @(negedge clk);
      expect_rd(4, 32'h000, "R3 no refire while equality held");
      set_pos(12'h124);
      set_pos(12'h123);
      expect_rd(4, 32'h040, "R3 refire after leaving and returning");

      // R4 revolution compare and R5 combined
      set_idx(8'h05);
      expect_rd(4, 32'h640, "R4 revolution match with R5 combined 0");
      wr(6, 32'h400);
      expect_rd(4, 32'h640, "R5 combined rearms while sources pending");
      wr(6, 32'h240);
      expect_rd(4, 32'h400, "R5 combined sticky after sources cleared");
      wr(6, 32'h400);
      expect_rd(4, 32'h000, "R6 combined cleared");

      // R8 hardware wins over a same-cycle clear
      @(negedge clk);
      pos_cnt = 12'h456; src_evt = 6'b010000;
      wr_en = 1'b1; wr_addr = ADDR_W'(6); wr_data = 32'h090;
      @(negedge clk);
      wr_en = 1'b0; src_evt = '0;
      expect_rd(4, 32'h090, "R8 pulse and compare beat clear");

      // R7 software set feeding R5 combined 1
      wr(5, 32'h200);
      expect_rd(4, 32'hA90, "R7 set bit 9 yields R5 combined 1");

      // R11 status is read only; R7 upper data bits ignored
      wr(4, 32'h1FFF);
      expect_rd(4, 32'hA90, "R11 write to status address ignored");
      wr(5, 32'hFFFF_E000);
      expect_rd(4, 32'hA90, "R7 data bits above 12 ignored");
      expect_rd(12, 32'h0, "R11 unmapped address reads zero");

      // R10 with a single enabled combined bit
      wr(7, 32'h800);
      expect_irq(1'b1, "R10 irq from combined bit 11");
      wr(6, 32'h800);
      expect_irq(1'b1, "R10 irq stays, R5 combined rearmed");
      wr(6, 32'h1FFF);
      expect_rd(4, 32'h000, "R6 clear all");
      expect_irq(1'b0, "R10 irq low after clear all");

      // R4 at the top revolution value
      wr(3, 32'hFF);
      set_idx(8'hFF);
      expect_rd(4, 32'h200, "R4 revolution match at 0xFF");
      wr(3, 32'h1FF);
      expect_rd(3, 32'hFF, "R11 revolution ref truncated to IDX_W");
      expect_rd(4, 32'h200, "R4 no refire on same-value rewrite");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule